// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Multiplier

This block executes the four multiply variants of an integer multiply/divide instruction group. It receives a 32-bit instruction word and two register operand values. It decodes which variant the instruction asks for and returns one register-wide result. The result is either the low or the high half of the double-width product. For the high-half variants, the first operand is read as signed or unsigned, and so is the second, each on its own, as the variant dictates.

The computation is sequential. Each operand is widened by one bit, using sign or zero extension. A shift-and-add datapath then takes one multiplier bit per cycle, and the final step subtracts the partial product of the sign bit. A one-cycle `start` launches an operation. `busy` stays high while it runs, and a one-cycle `done` marks a valid `result`.

If `start` comes with an instruction outside the multiply group, the block raises a one-cycle `illegal` pulse instead. The division-group function codes also count as illegal here. A `start` that arrives while an operation is in flight is dropped.

Top module: `mulu_top`

## Requirements
- R1: An instruction is a multiply only when bits 31:25 are 0000001, bits 6:2 are 01100, bits 1:0 are 11, and bit 14 (the top bit of the function code in bits 14:12) is 0. Bits 24:15 and 11:7 are ignored.
- R2: Function code 000 returns bits XLEN-1:0 of the product of the two operands.
- R3: Function code 001 reads both operands as signed and returns bits 2*XLEN-1:XLEN of the product.
- R4: Function code 010 reads rs1 as signed and rs2 as unsigned and returns the upper XLEN bits of the product.
- R5: Function code 011 reads both operands as unsigned and returns the upper XLEN bits of the product.
- R6: A `start` with an instruction that R1 rejects raises `illegal` for exactly one cycle, in the cycle after the start edge. `done` stays low and `result` keeps its previous value.
- R7: After an accepted `start`, `busy` is high for exactly XLEN+1 cycles, beginning in the cycle after the start edge. `done` is then high for exactly one cycle, XLEN+2 cycles after the start edge, and `busy` is low in that cycle.
- R8: A `start` seen while `busy` is high has no effect: no `illegal`, no extra `done`, and the running operation's result is unchanged.
- R9: Reset (`rst_n` low) clears `busy`, `done` and `illegal` and sets `result` to zero, including in the middle of an operation.
- R10: With function code 001, 0x80000000 times 0x80000000 returns 0x40000000, and with function code 000 it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 32 | Instruction word to decode |
| rs1_val | input | XLEN | First operand value |
| rs2_val | input | XLEN | Second operand value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| illegal | output | 1 | One-cycle pulse: the last start carried a non-multiply encoding |
| result | output | XLEN | Selected product half; holds between operations |

## Verification
The bench builds the block with XLEN at its default of 32. At that width the most negative operand 0x80000000 can be reached, so the sign-bit subtraction of the final step is exercised by the R10 corner and by mixed-sign pairs under each function code. A 33-cycle busy window leaves room to fire a second start in the middle of an operation and to pull reset part-way through one. Expected products come from 64-bit arithmetic in the bench, which does not depend on the widened 33-bit datapath.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

  localparam logic [6:0] MUL_GRP_HI = 7'b0000001;
  localparam logic [4:0] MUL_OPCODE = 5'b01100;
  localparam logic [1:0] MUL_LENBITS = 2'b11;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic take_high;
  } mul_cfg_t;

endpackage

// File: rtl/mulu_decode.sv
module mulu_decode
  import mulu_pkg::*;
(
  input  logic [31:0] instr,
  output logic        legal,
  output mul_cfg_t    cfg
);

  logic [2:0] fcode;
  logic       unused_fields;

  assign fcode         = instr[14:12];
  assign unused_fields = ^{instr[24:15], instr[11:7]};

  always_comb begin
    legal = (instr[31:25] == MUL_GRP_HI) &&
            (instr[6:2]   == MUL_OPCODE) &&
            (instr[1:0]   == MUL_LENBITS) &&
            !fcode[2];
    case (fcode[1:0])
      2'b00:   cfg = '{a_signed: 1'b1, b_signed: 1'b1, take_high: 1'b0};
      2'b01:   cfg = '{a_signed: 1'b1, b_signed: 1'b1, take_high: 1'b1};
      2'b10:   cfg = '{a_signed: 1'b1, b_signed: 1'b0, take_high: 1'b1};
      default: cfg = '{a_signed: 1'b0, b_signed: 1'b0, take_high: 1'b1};
    endcase
  end

endmodule

// File: rtl/mulu_shiftadd.sv
module mulu_shiftadd
  import mulu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  mul_cfg_t       cfg,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           busy,
  output logic           last_step,
  output logic [2*W-1:0] prod
);

  localparam int OW = W + 1;
  localparam int PW = 2 * W + 2;
  localparam int CW = $clog2(OW + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OW - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [PW-1:0] mcand_q, mcand_d;
  logic [OW-1:0] mplier_q, mplier_d;
  logic          step_en;

  logic [OW-1:0] a_ext, b_ext;
  logic [PW-1:0] addend, sum;

  assign a_ext = {cfg.a_signed & a_in[W-1], a_in};
  assign b_ext = {cfg.b_signed & b_in[W-1], b_in};

  assign last_step = busy_q && (cnt_q == LAST_CNT);
  assign addend    = !mplier_q[0] ? '0 : (last_step ? -mcand_q : mcand_q);
  assign sum       = acc_q + addend;
  assign prod      = sum[2*W-1:0];
  assign busy      = busy_q;
  assign step_en   = load || busy_q;

  always_comb begin
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    if (load) begin
      busy_d   = 1'b1;
      cnt_d    = '0;
      acc_d    = '0;
      mcand_d  = {{(PW-OW){a_ext[OW-1]}}, a_ext};
      mplier_d = b_ext;
    end else if (busy_q) begin
      busy_d   = !last_step;
      cnt_d    = cnt_q + CW'(1);
      acc_d    = sum;
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (step_en) begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST_CNT)); // R7
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && cnt_q == '0 && acc_q == '0)); // R7

endmodule

// File: rtl/mulu_top.sv
module mulu_top
  import mulu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] result
);

  logic            legal;
  mul_cfg_t        dec_cfg;
  logic            accept, reject;
  logic            dp_busy, dp_last;
  logic [2*XLEN-1:0] dp_prod;

  logic            hi_q, hi_d;
  logic            done_q, done_d;
  logic            ill_q, ill_d;
  logic [XLEN-1:0] res_q, res_d;

  mulu_decode u_dec (
    .instr (instr),
    .legal (legal),
    .cfg   (dec_cfg)
  );

  assign accept = start && !dp_busy && legal;
  assign reject = start && !dp_busy && !legal;

  mulu_shiftadd #(.W(XLEN)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .cfg       (dec_cfg),
    .a_in      (rs1_val),
    .b_in      (rs2_val),
    .busy      (dp_busy),
    .last_step (dp_last),
    .prod      (dp_prod)
  );

  always_comb begin
    hi_d   = accept ? dec_cfg.take_high : hi_q;
    done_d = dp_last;
    ill_d  = reject;
    res_d  = res_q;
    if (dp_last) begin
      res_d = hi_q ? dp_prod[2*XLEN-1:XLEN] : dp_prod[XLEN-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (dp_last) begin
      res_q <= res_d;
    end
  end

  assign busy    = dp_busy;
  assign done    = done_q;
  assign illegal = ill_q;
  assign result  = res_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && legal) |=> busy); // R7
  AST_ILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal); // R6
  AST_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && done)); // R6
  AST_ILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(result)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !illegal); // R8

endmodule

// File: tb/mulu_top_test.sv
module mulu_top_test;

  localparam int XLEN = 32;

  typedef struct {
    bit          is_ill;
    logic [31:0] val;
    string       req;
  } sb_item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1_val = '0;
  logic [XLEN-1:0] rs2_val = '0;
  logic            busy, done, illegal;
  logic [XLEN-1:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] last_res = '0;
  sb_item_t sbq[$];

  always #2 clk = ~clk;

  mulu_top #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val),
    .busy(busy), .done(done), .illegal(illegal), .result(result)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] f3);
    return {7'b0000001, 5'd7, 5'd9, f3, 5'd4, 5'b01100, 2'b11};
  endfunction

  function automatic logic [31:0] model(input logic [2:0] f3, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub, p;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (f3[1:0])
      2'b00:   begin p = sa * sb; return p[31:0]; end
      2'b01:   p = sa * sb;
      2'b10:   p = sa * ub;
      default: p = ua * ub;
    endcase
    return p[63:32];
  endfunction

  // monitor: pops the scoreboard whenever the design reports
  always @(negedge clk) begin
    if (rst_n && (done || illegal)) begin
      if (sbq.size() == 0) begin
        check(0, "R8 unexpected report", result, 32'h0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(it.is_ill == illegal && it.is_ill != done, {it.req, " kind"},
              {30'b0, done, illegal}, {30'b0, !it.is_ill, it.is_ill});
        check(result == it.val, {it.req, " value"}, result, it.val);
      end
    end
  end

  // driver: one operation, also measures busy window and latency
  task automatic run_op(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input bit exp_ill,
                        input logic [31:0] exp, input string req);
    sb_item_t it;
    int k, bcnt;
    it.is_ill = exp_ill;
    it.val = exp_ill ? last_res : exp;
    it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    instr = ins; rs1_val = a; rs2_val = b; start = 1'b1;
    bcnt = 0;
    for (k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (busy) bcnt++;
      if (done || illegal) break;
    end
    if (exp_ill) begin
      check(k == 1, "R6 illegal latency", k, 1);
    end else begin
      check(k == XLEN + 2, "R7 done latency", k, XLEN + 2);
      check(bcnt == XLEN + 1, "R7 busy cycles", bcnt, XLEN + 1);
      last_res = exp;
    end
    @(negedge clk);
    check(!done && !illegal, "R7 single pulse", {30'b0, done, illegal}, 0);
  endtask

  task automatic mul_op(input logic [2:0] f3, input logic [31:0] a,
                        input logic [31:0] b, input string req);
    run_op(mk(f3), a, b, 0, model(f3, a, b), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !illegal, "R9 reset flags", {29'b0, busy, done, illegal}, 0);
    check(result == 0, "R9 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 low half
    mul_op(3'b000, 32'd7, 32'd6, "R2 small");
    mul_op(3'b000, 32'hFFFF_FFFF, 32'd5, "R2 neg");
    mul_op(3'b000, 32'h1234_5678, 32'h9ABC_DEF0, "R2 mix");
    // R3 signed high
    mul_op(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 minus1 sq");
    mul_op(3'b001, 32'h7FFF_FFFF, 32'h8000_0000, "R3 maxmin");
    mul_op(3'b001, 32'hDEAD_BEEF, 32'h0000_1000, "R3 mix");
    // R10 corner
    run_op(mk(3'b001), 32'h8000_0000, 32'h8000_0000, 0, 32'h4000_0000, "R10 hi");
    run_op(mk(3'b000), 32'h8000_0000, 32'h8000_0000, 0, 32'h0, "R10 lo");
    // R4 signed x unsigned
    mul_op(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 neg x big");
    mul_op(3'b010, 32'h8000_0000, 32'h8000_0000, "R4 min x big");
    mul_op(3'b010, 32'h0000_0003, 32'hF000_0000, "R4 pos");
    // R5 unsigned high
    mul_op(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max sq");
    mul_op(3'b011, 32'h8000_0000, 32'h0000_0002, "R5 carry");

    // R1/R6 rejected encodings; result holds
    run_op(mk(3'b100), 32'd3, 32'd4, 1, 0, "R6 fcode 100");
    run_op(mk(3'b111), 32'd3, 32'd4, 1, 0, "R6 fcode 111");
    run_op(mk(3'b001) ^ 32'h0200_0000, 32'd3, 32'd4, 1, 0, "R1 group bits");
    run_op(mk(3'b001) ^ 32'h0000_0010, 32'd3, 32'd4, 1, 0, "R1 opcode");
    run_op(mk(3'b001) & ~32'h1, 32'd3, 32'd4, 1, 0, "R1 low bits");
    // R1 ignored register fields
    run_op(mk(3'b011) ^ 32'h01FF_8F80, 32'h0001_0000, 32'h0001_0000, 0,
           32'h0000_0001, "R1 fields ignored");

    // R8 start while busy
    begin
      sb_item_t it;
      it.is_ill = 0; it.val = model(3'b011, 32'hABCD_0000, 32'h0000_0100);
      it.req = "R8 first op kept";
      sbq.push_back(it);
      @(negedge clk);
      instr = mk(3'b011); rs1_val = 32'hABCD_0000; rs2_val = 32'h0000_0100; start = 1;
      @(negedge clk); start = 0;
      repeat (4) @(negedge clk);
      instr = mk(3'b000); rs1_val = 32'd9; rs2_val = 32'd9; start = 1;
      @(negedge clk);
      instr = 32'h0; start = 1;
      @(negedge clk); start = 0;
      repeat (70) @(negedge clk);
      check(sbq.size() == 0, "R8 queue drained", sbq.size(), 0);
      check(result == it.val, "R8 result", result, it.val);
      last_res = it.val;
    end

    // R2..R5 pseudo-random sweep
    lf = 32'hACE1_2345;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a = lf * 32'h9E37_79B9;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b = lf ^ 32'h5A5A_1234;
      mul_op(3'(i % 4), a, b, "R2-R5 sweep");
    end

    // R9 reset mid-operation
    @(negedge clk);
    instr = mk(3'b001); rs1_val = 32'h1234_5678; rs2_val = 32'h1111_1111; start = 1;
    @(negedge clk); start = 0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    sbq.delete();
    @(negedge clk);
    check(!busy && !done && !illegal, "R9 midop flags", {29'b0, busy, done, illegal}, 0);
    check(result == 0, "R9 midop result", result, 0);
    rst_n = 1'b1;
    last_res = 0;
    repeat (40) @(negedge clk);
    check(!busy && result == 0, "R9 stays idle", result, 0);
    mul_op(3'b000, 32'd11, 32'd13, "R9 after reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule